// File: doc/BRIEF.md
# Lookahead Greedy Cache-Way Allocator

This block divides the ways of a shared cache among several applications. Each application has a cost curve that gives its expected penalty, for example weighted misses plus writebacks, for every way count from 0 to the total number of ways. Software or a neighbouring unit writes these curves into an internal table through a single write port. A start pulse then launches the allocation.

The engine first gives every application one way. It then repeats a selection step until no way is left. In each step it looks at every application and at every increment that still fits in the pool. It grants the increment with the largest cost drop per way. Because an increment of several ways is ranked by its average gain, the engine can step across a flat stretch of a curve to reach a cliff further on. A one-way-at-a-time allocator would never cross such a stretch.

When every way is assigned, the engine raises done and presents one way count per application on a packed output. The counts stay there until the next run completes. The computation is meant to run once per long epoch of several million cycles, so it takes one candidate per cycle and has no divider.

Top module: `lga_way_allocator`

## Requirements
- R1: After reset, done is 0 and every lane of the allocation output is 0.
- R2: Each run first gives every application exactly 1 way, so every lane of a completed result is at least 1.
- R3: A step ranks each candidate (application i, increment d), for d from 1 to the number of unassigned ways, by (cost_i(w_i) − cost_i(w_i+d)) / d. Here w_i is the current count of application i and the cost entries are unsigned 32-bit values. The step adds the winning d to the winning application.
- R4: Ties are broken by scan order: lower application index first, then smaller increment. A later candidate wins only with a strictly larger merit.
- R5: Steps repeat until the assigned ways total the pool size M exactly. done then rises and the output lanes sum to M.
- R6: A candidate whose merit is negative is still eligible. Every step grants at least one way and never more than the unassigned count.
- R7: done stays 1 until the next accepted start, and is 0 while a run is in progress. The allocation output changes only in the cycle where done rises, so it holds the previous result during a run.
- R8: A start pulse that arrives while a run is in progress is ignored. The run continues and produces the same result it would have produced without the pulse.
- R9: A table write with application a, way count w and value v sets the entry cost_a(w) to v. A later write to the same entry replaces it.
- R10: With F = M − N, a run finishes within N·F·(F+1)/2 + 2·F + 3 cycles of the clock edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write strobe for the cost table |
| tbl_wr_app | input | APP_W | Application index of the entry written |
| tbl_wr_ways | input | WAY_W | Way count of the entry written (0..M) |
| tbl_wr_cost | input | 32 | Unsigned cost value written |
| start | input | 1 | Begins a run when the engine is idle |
| done | output | 1 | Result valid; held until the next accepted start |
| way_alloc | output | NUM_APPS·WAY_W | Way count of application i in bits [i·WAY_W +: WAY_W] |

## Verification
The hardest situations to reach are steps in which the winner comes from a tie or from a set of candidates that all have negative merit. The hardest of all is a step where a multi-way increment beats every single-way one, because random curves rarely produce a flat stretch followed by a cliff. The bench sets these up on purpose with constant curves, linear rising curves with equal slopes in two applications, and a curve that is flat for one way and then drops sharply. It then runs many random curves with very small values, which makes exact ties in the cross-multiplied comparison common. A second start pulse is injected in the middle of a scan to show that it leaves the run unchanged.

// File: rtl/lga_pkg.sv
package lga_pkg;

  localparam int COST_W = 32;
  localparam int STEP_W = 16;
  localparam int PROD_W = COST_W + 1 + STEP_W + 1;

  typedef logic [COST_W-1:0]        cost_t;
  typedef logic signed [COST_W:0]   gain_t;
  typedef logic [STEP_W-1:0]        step_t;
  typedef logic signed [PROD_W-1:0] prod_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SCAN,
    ST_COMMIT
  } eng_state_e;

  // Cost drop when moving from the current point to a later point of a curve.
  function automatic gain_t cost_gain(cost_t now_c, cost_t next_c);
    gain_t a;
    gain_t b;
    a = gain_t'({1'b0, now_c});
    b = gain_t'({1'b0, next_c});
    return a - b;
  endfunction

  // True when cand_g/cand_n is strictly above best_g/best_n (both n > 0).
  function automatic logic merit_beats(gain_t cand_g, step_t cand_n,
                                       gain_t best_g, step_t best_n);
    prod_t lhs;
    prod_t rhs;
    lhs = prod_t'(cand_g) * prod_t'({1'b0, best_n});
    rhs = prod_t'(best_g) * prod_t'({1'b0, cand_n});
    return lhs > rhs;
  endfunction

endpackage

// File: rtl/lga_cost_table.sv
module lga_cost_table
  import lga_pkg::*;
#(
  parameter int NUM_APPS = 8,
  parameter int NUM_WAYS = 64,
  parameter int APP_W    = 3,
  parameter int WAY_W    = 7
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [APP_W-1:0] wr_app,
  input  logic [WAY_W-1:0] wr_ways,
  input  cost_t            wr_cost,
  input  logic [APP_W-1:0] rd_app,
  input  logic [WAY_W-1:0] rd_ways_lo,
  input  logic [WAY_W-1:0] rd_ways_hi,
  output cost_t            rd_cost_lo,
  output cost_t            rd_cost_hi
);

  localparam int STRIDE = NUM_WAYS + 1;
  localparam int DEPTH  = NUM_APPS * STRIDE;
  localparam int IDX_W  = $clog2(DEPTH);

  cost_t mem_q [DEPTH];

  function automatic logic [IDX_W-1:0] flat_idx(logic [APP_W-1:0] app,
                                                logic [WAY_W-1:0] ways);
    return IDX_W'(app) * IDX_W'(STRIDE) + IDX_W'(ways);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[flat_idx(wr_app, wr_ways)] <= wr_cost;
    end
  end

  assign rd_cost_lo = mem_q[flat_idx(rd_app, rd_ways_lo)];
  assign rd_cost_hi = mem_q[flat_idx(rd_app, rd_ways_hi)];

endmodule

// File: rtl/lga_scan_ctr.sv
module lga_scan_ctr #(
  parameter int NUM_APPS = 8,
  parameter int APP_W    = 3,
  parameter int WAY_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [WAY_W-1:0] free_ways,
  output logic [APP_W-1:0] app_idx,
  output logic [WAY_W-1:0] step_ways,
  output logic             last
);

  logic [APP_W-1:0] app_q;
  logic [WAY_W-1:0] step_q;
  logic             step_end;

  assign step_end = (step_q >= free_ways);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      app_q  <= '0;
      step_q <= WAY_W'(1);
    end else if (clear) begin
      app_q  <= '0;
      step_q <= WAY_W'(1);
    end else if (advance) begin
      if (step_end) begin
        step_q <= WAY_W'(1);
        app_q  <= app_q + APP_W'(1);
      end else begin
        step_q <= step_q + WAY_W'(1);
      end
    end
  end

  assign app_idx   = app_q;
  assign step_ways = step_q;
  assign last      = step_end && (app_q == APP_W'(NUM_APPS - 1));

endmodule

// File: rtl/lga_best_track.sv
module lga_best_track
  import lga_pkg::*;
#(
  parameter int APP_W = 3,
  parameter int WAY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cand_valid,
  input  gain_t            cand_gain,
  input  logic [APP_W-1:0] cand_app,
  input  logic [WAY_W-1:0] cand_step,
  output logic             take,
  output logic [APP_W-1:0] best_app,
  output logic [WAY_W-1:0] best_step
);

  logic             have_q;
  gain_t            best_gain_q;
  logic [APP_W-1:0] best_app_q;
  logic [WAY_W-1:0] best_step_q;

  // An empty slot acts as the most negative merit; otherwise strict greater wins.
  assign take = cand_valid &&
                (!have_q || merit_beats(cand_gain, step_t'(cand_step),
                                        best_gain_q, step_t'(best_step_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q      <= 1'b0;
      best_gain_q <= '0;
      best_app_q  <= '0;
      best_step_q <= '0;
    end else if (clear) begin
      have_q <= 1'b0;
    end else if (take) begin
      have_q      <= 1'b1;
      best_gain_q <= cand_gain;
      best_app_q  <= cand_app;
      best_step_q <= cand_step;
    end
  end

  assign best_app  = best_app_q;
  assign best_step = best_step_q;

endmodule

// File: rtl/lga_way_allocator.sv
module lga_way_allocator
  import lga_pkg::*;
#(
  parameter  int NUM_APPS = 8,
  parameter  int NUM_WAYS = 64,
  localparam int APP_W    = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
  localparam int WAY_W    = $clog2(NUM_WAYS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tbl_wr_en,
  input  logic [APP_W-1:0]          tbl_wr_app,
  input  logic [WAY_W-1:0]          tbl_wr_ways,
  input  logic [COST_W-1:0]         tbl_wr_cost,
  input  logic                      start,
  output logic                      done,
  output logic [NUM_APPS*WAY_W-1:0] way_alloc
);

  eng_state_e       state_q;
  logic             done_q;
  logic [WAY_W-1:0] work_q   [NUM_APPS];
  logic [WAY_W-1:0] result_q [NUM_APPS];
  logic [WAY_W-1:0] used_q;

  // Named internal events used by the bound checker.
  logic             busy;
  logic             start_accept;
  logic             step_commit;
  logic             pool_full;
  logic [WAY_W-1:0] free_w;

  logic             scan_clear;
  logic             scan_adv;
  logic [APP_W-1:0] scan_app;
  logic [WAY_W-1:0] scan_step;
  logic             scan_last;

  logic [WAY_W-1:0] cur_ways;
  logic [WAY_W-1:0] next_ways;
  cost_t            cost_lo;
  cost_t            cost_hi;
  gain_t            cand_gain;

  logic             cand_take;
  logic [APP_W-1:0] best_app;
  logic [WAY_W-1:0] best_step;

  assign busy         = (state_q != ST_IDLE);
  assign start_accept = start && !busy;
  assign step_commit  = (state_q == ST_COMMIT);
  assign pool_full    = (used_q == WAY_W'(NUM_WAYS));
  assign free_w       = WAY_W'(NUM_WAYS) - used_q;

  assign scan_clear = (state_q == ST_CHECK);
  assign scan_adv   = (state_q == ST_SCAN);

  assign cur_ways  = work_q[scan_app];
  assign next_ways = cur_ways + scan_step;
  assign cand_gain = cost_gain(cost_lo, cost_hi);

  lga_cost_table #(
    .NUM_APPS (NUM_APPS),
    .NUM_WAYS (NUM_WAYS),
    .APP_W    (APP_W),
    .WAY_W    (WAY_W)
  ) table_i (
    .clk        (clk),
    .wr_en      (tbl_wr_en),
    .wr_app     (tbl_wr_app),
    .wr_ways    (tbl_wr_ways),
    .wr_cost    (tbl_wr_cost),
    .rd_app     (scan_app),
    .rd_ways_lo (cur_ways),
    .rd_ways_hi (next_ways),
    .rd_cost_lo (cost_lo),
    .rd_cost_hi (cost_hi)
  );

  lga_scan_ctr #(
    .NUM_APPS (NUM_APPS),
    .APP_W    (APP_W),
    .WAY_W    (WAY_W)
  ) scan_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (scan_clear),
    .advance   (scan_adv),
    .free_ways (free_w),
    .app_idx   (scan_app),
    .step_ways (scan_step),
    .last      (scan_last)
  );

  lga_best_track #(
    .APP_W (APP_W),
    .WAY_W (WAY_W)
  ) best_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (scan_clear),
    .cand_valid (scan_adv),
    .cand_gain  (cand_gain),
    .cand_app   (scan_app),
    .cand_step  (scan_step),
    .take       (cand_take),
    .best_app   (best_app),
    .best_step  (best_step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      used_q  <= '0;
      for (int i = 0; i < NUM_APPS; i++) begin
        work_q[i]   <= '0;
        result_q[i] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_accept) begin
            for (int i = 0; i < NUM_APPS; i++) begin
              work_q[i] <= WAY_W'(1);
            end
            used_q  <= WAY_W'(NUM_APPS);
            done_q  <= 1'b0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (pool_full) begin
            for (int i = 0; i < NUM_APPS; i++) begin
              result_q[i] <= work_q[i];
            end
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_last) begin
            state_q <= ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          work_q[best_app] <= work_q[best_app] + best_step;
          used_q           <= used_q + best_step;
          state_q          <= ST_CHECK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done = done_q;

  for (genvar g = 0; g < NUM_APPS; g++) begin : g_lane
    assign way_alloc[g*WAY_W +: WAY_W] = result_q[g];
  end

endmodule

// File: rtl/lga_way_allocator_chk.sv
module lga_way_allocator_chk #(
  parameter int NUM_APPS = 8,
  parameter int NUM_WAYS = 64,
  parameter int WAY_W    = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      done,
  input logic [NUM_APPS*WAY_W-1:0] way_alloc,
  input logic                      busy,
  input logic [WAY_W-1:0]          used_q,
  input logic                      step_commit,
  input logic [WAY_W-1:0]          commit_ways,
  input logic [WAY_W-1:0]          free_w
);

  int   lane_sum;
  logic lanes_pos;

  always_comb begin
    lane_sum  = 0;
    lanes_pos = 1'b1;
    for (int i = 0; i < NUM_APPS; i++) begin
      lane_sum = lane_sum + int'(way_alloc[i*WAY_W +: WAY_W]);
      if (way_alloc[i*WAY_W +: WAY_W] == '0) lanes_pos = 1'b0;
    end
  end

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R7
  alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(way_alloc));

  // R7
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> used_q >= $past(used_q));

  // R6
  grant_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_commit |-> (commit_ways != '0) && (commit_ways <= free_w));

  // R5
  total_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> lane_sum == NUM_WAYS);

  // R2
  lane_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> lanes_pos);

endmodule

bind lga_way_allocator lga_way_allocator_chk #(
  .NUM_APPS (NUM_APPS),
  .NUM_WAYS (NUM_WAYS),
  .WAY_W    (WAY_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .way_alloc   (way_alloc),
  .busy        (busy),
  .used_q      (used_q),
  .step_commit (step_commit),
  .commit_ways (best_step),
  .free_w      (free_w)
);

// File: tb/lga_way_allocator_tb_top.sv
`timescale 1ns/1ps
module lga_way_allocator_tb_top;

  localparam int N  = 4;
  localparam int M  = 10;
  localparam int AW = 2;
  localparam int WW = $clog2(M + 1);
  localparam int F  = M - N;
  localparam int LAT_BOUND = N * F * (F + 1) / 2 + 2 * F + 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tbl_wr_en;
  logic [AW-1:0] tbl_wr_app;
  logic [WW-1:0] tbl_wr_ways;
  logic [31:0]   tbl_wr_cost;
  logic          start;
  logic          done;
  logic [N*WW-1:0] way_alloc;

  always #10 clk = ~clk;

  lga_way_allocator #(.NUM_APPS(N), .NUM_WAYS(M)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_app  (tbl_wr_app),
    .tbl_wr_ways (tbl_wr_ways),
    .tbl_wr_cost (tbl_wr_cost),
    .start       (start),
    .done        (done),
    .way_alloc   (way_alloc)
  );

  int unsigned cost_tb [N][M+1];
  int exp_a  [N];
  int prev_a [N];
  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int lane(int i);
    return int'(way_alloc[i*WW +: WW]);
  endfunction

  // Reference: greedy with multi-way lookahead, ties to first in scan order.
  function automatic void model();
    int used;
    used = N;
    for (int i = 0; i < N; i++) exp_a[i] = 1;
    while (used < M) begin
      bit     have;
      longint bg;
      int     bi;
      int     bd;
      have = 0; bg = 0; bi = 0; bd = 1;
      for (int i = 0; i < N; i++) begin
        for (int d = 1; d <= M - used; d++) begin
          longint g;
          g = longint'(cost_tb[i][exp_a[i]]) - longint'(cost_tb[i][exp_a[i] + d]);
          if (!have || (g * bd > bg * d)) begin
            have = 1; bg = g; bi = i; bd = d;
          end
        end
      end
      exp_a[bi] += bd;
      used      += bd;
    end
  endfunction

  task automatic write_entry(int a, int w, int unsigned v);
    @(negedge clk);
    tbl_wr_en   = 1'b1;
    tbl_wr_app  = AW'(a);
    tbl_wr_ways = WW'(w);
    tbl_wr_cost = v;
    cost_tb[a][w] = v;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic load_all();
    for (int a = 0; a < N; a++)
      for (int w = 0; w <= M; w++)
        write_entry(a, w, cost_tb[a][w]);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R10 run did not finish", cyc, LAT_BOUND);
  endtask

  task automatic compare(string tag);
    int sum;
    sum = 0;
    for (int i = 0; i < N; i++) begin
      chk(lane(i) == exp_a[i], tag, lane(i), exp_a[i]);
      sum += lane(i);
    end
    chk(sum == M, "R5 lane sum", sum, M);
    for (int i = 0; i < N; i++) prev_a[i] = exp_a[i];
  endtask

  task automatic run(string tag);
    int cyc;
    model();
    pulse_start();
    wait_done(cyc);
    chk(cyc <= LAT_BOUND, "R10 latency bound", cyc, LAT_BOUND);
    compare(tag);
  endtask

  initial begin
    #(20.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_app = '0; tbl_wr_ways = '0;
    tbl_wr_cost = '0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(way_alloc == '0, "R1 alloc after reset", way_alloc, 0);

    // R2/R4: constant curves, every merit is 0, app 0 with d=1 wins each step
    for (int a = 0; a < N; a++) for (int w = 0; w <= M; w++) cost_tb[a][w] = 1000;
    load_all();
    run("R2 flat curves");
    chk(lane(0) == M - N + 1, "R4 tie to lowest app", lane(0), M - N + 1);
    chk(lane(3) == 1, "R2 floor of one way", lane(3), 1);

    // R7: done held and output stable while idle
    repeat (15) @(negedge clk);
    chk(done == 1'b1, "R7 done held", done, 1);
    chk(lane(0) == prev_a[0], "R7 output held", lane(0), prev_a[0]);

    // R9: overwrite one entry, app 3 now gains 1000 for its second way
    write_entry(3, 2, 0);
    run("R9 table overwrite");
    chk(lane(3) == 2, "R9 overwritten entry used", lane(3), 2);

    // R6/R4: rising linear curves, all merits negative; slopes 5,3,3,9
    for (int w = 0; w <= M; w++) begin
      cost_tb[0][w] = 100 + 5 * w;
      cost_tb[1][w] = 100 + 3 * w;
      cost_tb[2][w] = 100 + 3 * w;
      cost_tb[3][w] = 100 + 9 * w;
    end
    load_all();
    run("R6 negative merits");
    chk(lane(1) == M - N + 1, "R6 least negative, R4 lower index", lane(1), M - N + 1);

    // R3: cliff two ways ahead in app 2; others drop 10 per way
    for (int a = 0; a < N; a++) for (int w = 0; w <= M; w++) cost_tb[a][w] = 1000 - 10 * w;
    for (int w = 0; w <= M; w++) cost_tb[2][w] = (w <= 2) ? 1000 : 100;
    load_all();
    run("R3 lookahead cliff");
    chk(lane(2) == 3, "R3 multi-way grant", lane(2), 3);
    chk(lane(0) == 5, "R3 rest to app 0", lane(0), 5);

    // R7/R8: start pulse in the middle of a run
    for (int a = 0; a < N; a++) for (int w = 0; w <= M; w++) cost_tb[a][w] = $urandom;
    load_all();
    model();
    pulse_start();
    repeat (6) @(negedge clk);
    chk(done == 1'b0, "R7 done low while running", done, 0);
    chk(lane(2) == prev_a[2], "R7 old result kept while running", lane(2), prev_a[2]);
    pulse_start();
    wait_done(cyc);
    chk(cyc <= LAT_BOUND, "R8 latency with ignored start", cyc, LAT_BOUND);
    compare("R8 start while busy");

    // R3/R4/R5 random sweeps: wide values, then tiny values for frequent ties
    for (int r = 0; r < 40; r++) begin
      for (int a = 0; a < N; a++)
        for (int w = 0; w <= M; w++)
          cost_tb[a][w] = (r < 20) ? $urandom : $urandom_range(0, 3);
      load_all();
      run((r < 20) ? "R3 random wide" : "R4 random ties");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule